// File: doc/BRIEF.md
# USB charger port detection sequencer

This block works out what kind of USB power source has been plugged in and reports the input current the charger may draw from it. It reads the D+/D− lines only as digitized observations from comparators and analog front ends outside the block. It steps through four phases in a fixed order:

- data-contact detect;
- primary detection, which also recognizes vendor adapters that bias the data lines with resistor dividers;
- secondary detection;
- an optional high-voltage adapter request.

When a run finishes, the block drives a 4-bit source-type status code and a current-limit code in 10 mA steps. It also raises a done flag and a one-cycle interrupt pulse, both of which a mask input can hold back.

A plug event on `start_i` begins a run and a detach event on `detach_i` ends it. The comparator window flags show which voltage window each data line sits in. Three window levels are used, with this bit order in `dp_win_i` and `dm_win_i`:

| Bit | Window |
|-----|--------|
| 0 | 1.2 V |
| 1 | 2.0 V |
| 2 | 2.8 V |

While a high-voltage request is in progress, `hv_req_o` tells the signalling logic outside the block which voltage to ask for. That logic answers on `hv_ack_i` when the adapter accepts. Host enumeration, which keeps a charging downstream port from dropping back to a standard port, is handled elsewhere.

Top module: `chgdet_seq`

## Requirements
- R1: After reset the block is idle with `busy_o`=0, `done_o`=0, `irq_o`=0, `stat_o`=0000, `ilim_o`=0 and `hv_req_o`=00.
- R2: A `start_i` pulse while idle makes `busy_o` high from the next cycle, and `start_i` while busy is ignored. Data-contact detect leaves for primary detection as soon as `contact_i` is high, or after DCD_TMO_CYC cycles without contact.
- R3: At the end of primary detection (PRI_CYC cycles), an exact window pattern selects a divider adapter with status 0110, as listed in the divider table below. A divider match wins over any other primary outcome.
- R4: At the end of primary detection, if any window flag is set but no divider pattern matches, the result is an unknown adapter: status 0101, limit 300. This outranks `chg_port_i`.
- R5: If no window flag is set and `chg_port_i`=0 at the end of primary detection, the result is a standard port: status 0001, limit 50.
- R6: A charging port (`chg_port_i`=1) goes to secondary detection for SEC_CYC cycles. With `dcp_i`=0 at its end the result is status 0010, limit 150. With `dcp_i`=1 and no high-voltage request possible (`hv_en_i`=0, or both request enables 0) the result is status 0011, limit 325.
- R7: With `dcp_i`=1, `hv_en_i`=1 and a request enable set, a high-voltage attempt follows. `hv_req_o`=10 requests 12 V and 01 requests 9 V, and 12 V is tried first when both are enabled. `hv_ack_i` during an attempt gives status 0100, limit 150.
- R8: Each attempt lasts at most HV_CYC cycles. A failed 12 V attempt is followed by a 9 V attempt if 9 V is enabled. When every attempt fails, the result is status 0011, limit 325.
- R9: On completion `busy_o` falls and `stat_o`/`ilim_o` update in the same cycle. If `done_mask_i`=0, `done_o` goes high and `irq_o` pulses for exactly one cycle. If `done_mask_i`=1, both stay low.
- R10: `detach_i` aborts any phase and wins over `start_i`. In the next cycle `busy_o`, `done_o`, `stat_o`, `ilim_o` and `hv_req_o` are all 0.
- R11: Starting a run clears `stat_o`, `ilim_o` and `done_o`. A result is then held unchanged while idle until the next start or detach.

Divider table for R3 (window flags are the bit order given above; the limit is in 10 mA units):

| D+ window | D− window | Limit |
|-----------|-----------|-------|
| 2.8 V | 2.0 V | 210 |
| 1.2 V | 1.2 V | 200 |
| 2.0 V | 2.8 V | 100 |
| 2.8 V | 2.8 V | 240 |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Plug event, starts a run |
| detach_i | input | 1 | Detach event, aborts and clears |
| contact_i | input | 1 | Data contact observed |
| dp_win_i | input | 3 | D+ window flags (bit0 1.2 V, bit1 2.0 V, bit2 2.8 V) |
| dm_win_i | input | 3 | D− window flags, same order |
| chg_port_i | input | 1 | Primary detection saw a charging port |
| dcp_i | input | 1 | Secondary detection saw a dedicated port |
| hv_ack_i | input | 1 | Adapter accepted the current high-voltage request |
| hv_en_i | input | 1 | High-voltage handshake enable |
| req12_en_i | input | 1 | 12 V request enable |
| req9_en_i | input | 1 | 9 V request enable |
| done_mask_i | input | 1 | Suppresses done flag and interrupt |
| busy_o | output | 1 | Detection in progress |
| hv_req_o | output | 2 | 10 = 12 V request, 01 = 9 V request |
| stat_o | output | 4 | Source-type status code |
| ilim_o | output | ILIM_W | Current limit, 10 mA units |
| done_o | output | 1 | Detection complete |
| irq_o | output | 1 | One-cycle completion interrupt |

## Verification
The bench builds the block with DCD_TMO_CYC=10, PRI_CYC=4, SEC_CYC=3 and HV_CYC=5 in place of the multi-millisecond defaults. With these values the contact timeout and a failed 12 V attempt followed by a failed 9 V attempt complete within a few dozen cycles. The busy time can then be compared exactly against PRI_CYC+1 with contact and DCD_TMO_CYC+PRI_CYC without it. The short windows also let a detach land inside a running high-voltage attempt, and a second start arrive in the middle of primary detection.

// File: rtl/chgdet_pkg.sv
package chgdet_pkg;

  // Comparator window bit positions on each data line
  localparam int LVL_N   = 3;
  localparam int LVL_1V2 = 0;
  localparam int LVL_2V0 = 1;
  localparam int LVL_2V8 = 2;

  localparam int STAT_W  = 4;
  localparam int DIV_N   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DCD,
    ST_PRI,
    ST_SEC,
    ST_HV12,
    ST_HV9
  } phase_e;

  typedef enum logic [3:0] {
    SRC_NONE,
    SRC_SDP,
    SRC_CDP,
    SRC_DCP,
    SRC_HVDCP,
    SRC_UNK,
    SRC_DIV1,
    SRC_DIV2,
    SRC_DIV3,
    SRC_DIV4
  } src_e;

endpackage

// File: rtl/chgdet_timer.sv
module chgdet_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_we;

  always_comb begin
    cnt_we = clr_i | en_i;
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == (lim_i - CNT_W'(1)));

endmodule

// File: rtl/chgdet_divmap.sv
module chgdet_divmap
  import chgdet_pkg::*;
(
  input  logic [LVL_N-1:0] dp_win_i,
  input  logic [LVL_N-1:0] dm_win_i,
  output logic             div_hit_o,
  output logic             any_flag_o,
  output src_e             div_kind_o
);

  localparam logic [LVL_N-1:0] W12 = LVL_N'(1) << LVL_1V2;
  localparam logic [LVL_N-1:0] W20 = LVL_N'(1) << LVL_2V0;
  localparam logic [LVL_N-1:0] W28 = LVL_N'(1) << LVL_2V8;

  // Divider patterns, index order matches SRC_DIV1..SRC_DIV4
  localparam logic [LVL_N-1:0] DP_PAT [DIV_N] = '{W28, W12, W20, W28};
  localparam logic [LVL_N-1:0] DM_PAT [DIV_N] = '{W20, W12, W28, W28};

  logic [DIV_N-1:0] match;

  for (genvar g = 0; g < DIV_N; g++) begin : g_pat
    assign match[g] = (dp_win_i == DP_PAT[g]) && (dm_win_i == DM_PAT[g]);
  end

  always_comb begin
    div_kind_o = SRC_NONE;
    for (int i = DIV_N - 1; i >= 0; i--) begin
      if (match[i]) div_kind_o = src_e'(4'(SRC_DIV1) + 4'(i));
    end
  end

  assign div_hit_o  = |match;
  assign any_flag_o = (|dp_win_i) | (|dm_win_i);

endmodule

// File: rtl/chgdet_encode.sv
module chgdet_encode
  import chgdet_pkg::*;
#(
  parameter int ILIM_W = 9
) (
  input  src_e              kind_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [ILIM_W-1:0] ilim_o
);

  always_comb begin
    unique case (kind_i)
      SRC_SDP:   begin stat_o = 4'b0001; ilim_o = ILIM_W'(50);  end
      SRC_CDP:   begin stat_o = 4'b0010; ilim_o = ILIM_W'(150); end
      SRC_DCP:   begin stat_o = 4'b0011; ilim_o = ILIM_W'(325); end
      SRC_HVDCP: begin stat_o = 4'b0100; ilim_o = ILIM_W'(150); end
      SRC_UNK:   begin stat_o = 4'b0101; ilim_o = ILIM_W'(300); end
      SRC_DIV1:  begin stat_o = 4'b0110; ilim_o = ILIM_W'(210); end
      SRC_DIV2:  begin stat_o = 4'b0110; ilim_o = ILIM_W'(200); end
      SRC_DIV3:  begin stat_o = 4'b0110; ilim_o = ILIM_W'(100); end
      SRC_DIV4:  begin stat_o = 4'b0110; ilim_o = ILIM_W'(240); end
      default:   begin stat_o = '0;      ilim_o = '0;           end
    endcase
  end

endmodule

// File: rtl/chgdet_seq.sv
module chgdet_seq
  import chgdet_pkg::*;
#(
  parameter int DCD_TMO_CYC = 25_000_000,
  parameter int PRI_CYC     = 2_000_000,
  parameter int SEC_CYC     = 2_000_000,
  parameter int HV_CYC      = 5_000_000,
  parameter int ILIM_W      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              detach_i,
  input  logic              contact_i,
  input  logic [2:0]        dp_win_i,
  input  logic [2:0]        dm_win_i,
  input  logic              chg_port_i,
  input  logic              dcp_i,
  input  logic              hv_ack_i,
  input  logic              hv_en_i,
  input  logic              req12_en_i,
  input  logic              req9_en_i,
  input  logic              done_mask_i,
  output logic              busy_o,
  output logic [1:0]        hv_req_o,
  output logic [3:0]        stat_o,
  output logic [ILIM_W-1:0] ilim_o,
  output logic              done_o,
  output logic              irq_o
);

  localparam int MAX_AB  = (DCD_TMO_CYC > PRI_CYC) ? DCD_TMO_CYC : PRI_CYC;
  localparam int MAX_CD  = (SEC_CYC > HV_CYC) ? SEC_CYC : HV_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_in_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_in_n = rst_sync_q[1];

  // Phase state and its timer
  phase_e           st_q, st_d;
  logic             t_clr, t_en, t_last;
  logic [CNT_W-1:0] t_lim;

  always_comb begin
    unique case (st_q)
      ST_DCD:           t_lim = CNT_W'(DCD_TMO_CYC);
      ST_PRI:           t_lim = CNT_W'(PRI_CYC);
      ST_SEC:           t_lim = CNT_W'(SEC_CYC);
      ST_HV12, ST_HV9:  t_lim = CNT_W'(HV_CYC);
      default:          t_lim = CNT_W'(1);
    endcase
  end

  assign t_clr = (st_d != st_q) || (st_q == ST_IDLE);
  assign t_en  = (st_q != ST_IDLE);

  chgdet_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_in_n),
    .clr_i  (t_clr),
    .en_i   (t_en),
    .lim_i  (t_lim),
    .last_o (t_last)
  );

  // Line pattern classification
  logic div_hit, any_flag;
  src_e div_kind;

  chgdet_divmap u_divmap (
    .dp_win_i   (dp_win_i),
    .dm_win_i   (dm_win_i),
    .div_hit_o  (div_hit),
    .any_flag_o (any_flag),
    .div_kind_o (div_kind)
  );

  // Next-state decision
  logic fin, abort, begin_run;
  src_e fin_kind;
  logic hv12_ok, hv9_ok;

  assign hv12_ok = hv_en_i & req12_en_i;
  assign hv9_ok  = hv_en_i & req9_en_i;

  always_comb begin
    st_d      = st_q;
    fin       = 1'b0;
    fin_kind  = SRC_NONE;
    abort     = 1'b0;
    begin_run = 1'b0;
    if (detach_i) begin
      st_d  = ST_IDLE;
      abort = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_d      = ST_DCD;
          begin_run = 1'b1;
        end
        ST_DCD: if (contact_i || t_last) st_d = ST_PRI;
        ST_PRI: if (t_last) begin
          if (div_hit)         begin fin = 1'b1; fin_kind = div_kind; end
          else if (any_flag)   begin fin = 1'b1; fin_kind = SRC_UNK;  end
          else if (chg_port_i) st_d = ST_SEC;
          else                 begin fin = 1'b1; fin_kind = SRC_SDP;  end
        end
        ST_SEC: if (t_last) begin
          if (!dcp_i)       begin fin = 1'b1; fin_kind = SRC_CDP; end
          else if (hv12_ok) st_d = ST_HV12;
          else if (hv9_ok)  st_d = ST_HV9;
          else              begin fin = 1'b1; fin_kind = SRC_DCP; end
        end
        ST_HV12: begin
          if (hv_ack_i)    begin fin = 1'b1; fin_kind = SRC_HVDCP; end
          else if (t_last) begin
            if (hv9_ok) st_d = ST_HV9;
            else        begin fin = 1'b1; fin_kind = SRC_DCP; end
          end
        end
        ST_HV9: begin
          if (hv_ack_i)    begin fin = 1'b1; fin_kind = SRC_HVDCP; end
          else if (t_last) begin fin = 1'b1; fin_kind = SRC_DCP;   end
        end
        default: st_d = ST_IDLE;
      endcase
      if (fin) st_d = ST_IDLE;
    end
  end

  // Result encoding
  logic [STAT_W-1:0] enc_stat;
  logic [ILIM_W-1:0] enc_ilim;

  chgdet_encode #(.ILIM_W(ILIM_W)) u_enc (
    .kind_i (fin_kind),
    .stat_o (enc_stat),
    .ilim_o (enc_ilim)
  );

  // Output register next values and enables
  logic              res_we, done_we;
  logic [STAT_W-1:0] stat_q, stat_d;
  logic [ILIM_W-1:0] ilim_q, ilim_d;
  logic              done_q, done_d, irq_q, irq_d;

  always_comb begin
    res_we  = fin | abort | begin_run;
    done_we = res_we;
    if (fin) begin
      stat_d = enc_stat;
      ilim_d = enc_ilim;
      done_d = ~done_mask_i;
    end else begin
      stat_d = '0;
      ilim_d = '0;
      done_d = 1'b0;
    end
    irq_d = fin & ~done_mask_i;
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      st_q   <= ST_IDLE;
      stat_q <= '0;
      ilim_q <= '0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= irq_d;
      if (res_we) begin
        stat_q <= stat_d;
        ilim_q <= ilim_d;
      end
      if (done_we) done_q <= done_d;
    end
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign hv_req_o = {st_q == ST_HV12, st_q == ST_HV9};
  assign stat_o   = stat_q;
  assign ilim_o   = ilim_q;
  assign done_o   = done_q;
  assign irq_o    = irq_q;

endmodule

// File: rtl/chgdet_chk.sv
module chgdet_chk #(
  parameter int ILIM_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              detach_i,
  input logic              done_mask_i,
  input logic              busy_o,
  input logic [1:0]        hv_req_o,
  input logic [3:0]        stat_o,
  input logic [ILIM_W-1:0] ilim_o,
  input logic              done_o,
  input logic              irq_o
);

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);  // R9
  AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (done_o && !$past(done_mask_i)));  // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);  // R9
  AST_HV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hv_req_o));  // R7
  AST_HV_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_req_o != 2'b00) |-> busy_o);  // R7
  AST_DETACH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    detach_i |=> (!busy_o && !done_o && stat_o == 4'd0 && ilim_o == '0 && hv_req_o == 2'b00));  // R10
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !detach_i) |=> (busy_o && !done_o && stat_o == 4'd0 && ilim_o == '0));  // R11
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i && !detach_i) |=> ($stable(stat_o) && $stable(ilim_o)));  // R11

endmodule

bind chgdet_seq chgdet_chk #(.ILIM_W(ILIM_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .detach_i    (detach_i),
  .done_mask_i (done_mask_i),
  .busy_o      (busy_o),
  .hv_req_o    (hv_req_o),
  .stat_o      (stat_o),
  .ilim_o      (ilim_o),
  .done_o      (done_o),
  .irq_o       (irq_o)
);

// File: tb/sim_chgdet_seq.sv
`timescale 1ns/1ps
module sim_chgdet_seq;

  localparam int T_DCD  = 10;
  localparam int T_PRI  = 4;
  localparam int T_SEC  = 3;
  localparam int T_HV   = 5;
  localparam int ILIM_W = 9;

  logic clk = 1'b0;
  logic rst_n;
  logic start, detach, contact, chg, dcp, hv_ack, hven, r12, r9, mask;
  logic [2:0] dp, dm;
  logic busy, done, irq;
  logic [1:0] hv_req;
  logic [3:0] stat;
  logic [ILIM_W-1:0] ilim;
  logic a12, a9;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  chgdet_seq #(
    .DCD_TMO_CYC(T_DCD), .PRI_CYC(T_PRI), .SEC_CYC(T_SEC), .HV_CYC(T_HV), .ILIM_W(ILIM_W)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .detach_i(detach), .contact_i(contact),
    .dp_win_i(dp), .dm_win_i(dm), .chg_port_i(chg), .dcp_i(dcp), .hv_ack_i(hv_ack),
    .hv_en_i(hven), .req12_en_i(r12), .req9_en_i(r9), .done_mask_i(mask),
    .busy_o(busy), .hv_req_o(hv_req), .stat_o(stat), .ilim_o(ilim), .done_o(done), .irq_o(irq)
  );

  // Adapter model: accepts a request only for the voltages it is told to
  assign hv_ack = (hv_req == 2'b10 && a12) || (hv_req == 2'b01 && a9);

  typedef struct packed {
    logic [2:0] dp;
    logic [2:0] dm;
    logic       chg, dcp, hven, r12, r9, a12, a9;
    logic [3:0] stat;
    logic [8:0] ilim;
    logic [1:0] first;
    logic       saw9;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'b100, 3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0110, 9'd210, 2'b00, 1'b0},
    '{3'b001, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0110, 9'd200, 2'b00, 1'b0},
    '{3'b010, 3'b100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0110, 9'd100, 2'b00, 1'b0},
    '{3'b100, 3'b100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0110, 9'd240, 2'b00, 1'b0},
    '{3'b001, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0101, 9'd300, 2'b00, 1'b0},
    '{3'b100, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0101, 9'd300, 2'b00, 1'b0},
    '{3'b000, 3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0001, 9'd50,  2'b00, 1'b0},
    '{3'b000, 3'b000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0010, 9'd150, 2'b00, 1'b0},
    '{3'b000, 3'b000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0011, 9'd325, 2'b00, 1'b0},
    '{3'b000, 3'b000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0011, 9'd325, 2'b00, 1'b0},
    '{3'b000, 3'b000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0100, 9'd150, 2'b10, 1'b0},
    '{3'b000, 3'b000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'b0100, 9'd150, 2'b10, 1'b1},
    '{3'b000, 3'b000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0011, 9'd325, 2'b10, 1'b1},
    '{3'b000, 3'b000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0100, 9'd150, 2'b01, 1'b1},
    '{3'b100, 3'b010, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0110, 9'd210, 2'b00, 1'b0}
  };

  function automatic string tag_of(int i);
    if (i <= 3 || i == 14) return "R3";
    if (i <= 5)            return "R4";
    if (i == 6)            return "R5";
    if (i <= 9)            return "R6";
    if (i == 10 || i == 13) return "R7";
    return "R8";
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int busy_expect(input logic c);
    return c ? T_PRI + 1 : T_DCD + T_PRI;
  endfunction

  // One detection run; returns busy cycle count and observed requests
  int       busy_cnt;
  logic [1:0] first_req;
  logic     saw9;

  task automatic run(input bit extra_start);
    busy_cnt  = 0;
    first_req = 2'b00;
    saw9      = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (busy && busy_cnt < 500) begin
      busy_cnt++;
      if (first_req == 2'b00) first_req = hv_req;
      if (hv_req == 2'b01) saw9 = 1'b1;
      start = (extra_start && busy_cnt == 2);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic idle_inputs();
    start = 0; detach = 0; contact = 1; chg = 0; dcp = 0; hven = 0; r12 = 0; r9 = 0;
    mask = 0; dp = '0; dm = '0; a12 = 0; a9 = 0;
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 100000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "stat", stat, 0);
    chk("R1", "ilim", ilim, 0);
    chk("R1", "hv_req", hv_req, 0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      idle_inputs();
      dp = VECS[i].dp; dm = VECS[i].dm; chg = VECS[i].chg; dcp = VECS[i].dcp;
      hven = VECS[i].hven; r12 = VECS[i].r12; r9 = VECS[i].r9;
      a12 = VECS[i].a12; a9 = VECS[i].a9;
      run(1'b0);
      chk(tag_of(i), $sformatf("vec%0d stat", i), stat, VECS[i].stat);
      chk(tag_of(i), $sformatf("vec%0d ilim", i), ilim, VECS[i].ilim);
      chk(tag_of(i), $sformatf("vec%0d first request", i), first_req, VECS[i].first);
      chk(tag_of(i), $sformatf("vec%0d 9V tried", i), saw9, VECS[i].saw9);
      chk("R9", $sformatf("vec%0d done", i), done, 1);
      chk("R9", $sformatf("vec%0d irq on completion", i), irq, 1);
      @(negedge clk);
      chk("R9", $sformatf("vec%0d irq one cycle", i), irq, 0);
    end

    // R8 attempt length: 12 V and 9 V both time out after T_HV cycles each
    idle_inputs();
    chg = 1; dcp = 1; hven = 1; r12 = 1; r9 = 1;
    run(1'b0);
    chk("R8", "busy cycles two failed attempts", busy_cnt, T_PRI + 1 + T_SEC + 2 * T_HV);

    // R2 contact seen: DCD lasts one cycle
    idle_inputs();
    run(1'b0);
    chk("R2", "busy cycles with contact", busy_cnt, busy_expect(1'b1));
    chk("R5", "stat with contact", stat, 4'b0001);

    // R2 no contact: DCD times out and primary still runs
    idle_inputs();
    contact = 0;
    run(1'b0);
    chk("R2", "busy cycles on contact timeout", busy_cnt, busy_expect(1'b0));
    chk("R2", "stat after timeout", stat, 4'b0001);

    // R2 start while busy is ignored
    idle_inputs();
    run(1'b1);
    chk("R2", "busy cycles with second start", busy_cnt, busy_expect(1'b1));
    chk("R2", "busy after run with second start", busy, 0);

    // R9 masked completion
    idle_inputs();
    mask = 1;
    run(1'b0);
    chk("R9", "masked stat", stat, 4'b0001);
    chk("R9", "masked ilim", ilim, 50);
    chk("R9", "masked done", done, 0);
    chk("R9", "masked irq", irq, 0);
    @(negedge clk);
    chk("R9", "masked irq next", irq, 0);

    // R11 result held while idle, cleared on a new start
    idle_inputs();
    chg = 1;
    run(1'b0);
    repeat (5) @(negedge clk);
    chk("R11", "held stat", stat, 4'b0010);
    chk("R11", "held ilim", ilim, 150);
    chk("R11", "held done", done, 1);
    start = 1;
    @(negedge clk) start = 0;
    chk("R11", "stat cleared on start", stat, 0);
    chk("R11", "ilim cleared on start", ilim, 0);
    chk("R11", "done cleared on start", done, 0);
    chk("R2", "busy after start", busy, 1);
    while (busy) @(negedge clk);

    // R10 detach during primary detection
    idle_inputs();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (2) @(negedge clk);
    detach = 1;
    @(negedge clk) detach = 0;
    chk("R10", "busy after detach", busy, 0);
    chk("R10", "stat after detach", stat, 0);
    chk("R10", "done after detach", done, 0);
    repeat (T_PRI + 2) @(negedge clk);
    chk("R10", "no completion after detach", stat, 0);
    chk("R10", "no irq after detach", irq, 0);

    // R10 detach inside a high-voltage attempt
    idle_inputs();
    chg = 1; dcp = 1; hven = 1; r12 = 1;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    while (hv_req == 2'b00 && busy) @(negedge clk);
    chk("R7", "12V request active", hv_req, 2'b10);
    detach = 1;
    @(negedge clk) detach = 0;
    chk("R10", "hv_req after detach", hv_req, 0);
    chk("R10", "busy after hv detach", busy, 0);

    // R10 detach wins over start
    idle_inputs();
    detach = 1; start = 1;
    @(negedge clk);
    detach = 0; start = 0;
    chk("R10", "busy with start and detach", busy, 0);

    // R10 detach after completion clears result
    idle_inputs();
    run(1'b0);
    detach = 1;
    @(negedge clk) detach = 0;
    chk("R10", "stat cleared by idle detach", stat, 0);
    chk("R10", "done cleared by idle detach", done, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule